// File: doc/BRIEF.md
# Bridge Delta-Sigma Conversion Sequencer

This block is the digital half of a first-order delta-sigma converter whose integrator, comparator, reference and input multiplexer sit outside the chip. On every modulator tick it samples a one-bit comparator decision and answers with a one-bit feedback level that steers the external RC integrator back toward the reference. While a conversion window is open it also counts how many ticks reported the reference above the integrator node.

A conversion covers both halves of a resistive bridge. After a start request the block selects the first leg, lets the loop settle for a programmable number of discarded ticks, then counts over a fixed window of 1024 ticks. It switches the multiplexer select to the second leg, settles again and counts a second window. The two counts are subtracted into a signed differential result, so any offset shared by the common analog path drops out. A one-clock done pulse marks the result as valid.

The modulator rate is set by a tick enable input, so the loop can run far slower than the system clock. Nothing moves on clocks without a tick.

Top module: `bridge_dsm_ctrl`

## Requirements
- R1: A start pulse seen while idle makes busy high and leg_sel low (first leg) from the next clock on.
- R2: On each tick while busy, fb_out becomes the inverse of cmp_in (cmp_in=1, reference above integrator node, drives fb_out low); this holds in settling and in counting.
- R3: Each leg counts cmp_in=1 ticks over exactly 1024 counting ticks from a cleared count, and the result is count(leg 0) minus count(leg 1) as a 12-bit two's-complement value.
- R4: The settle_ticks value sampled at start sets how many ticks are discarded after start and again after the leg switch; a value of 0 discards none.
- R5: leg_sel goes high on the clock after the last tick of the first window, stays high through the second leg, and returns low when the conversion ends.
- R6: done is high for exactly one clock, in the same clock that busy first reads low, and result keeps its value until the next done.
- R7: A start pulse while busy is ignored: the running conversion and its result are unchanged.
- R8: On clocks without tick_en, fb_out and leg_sel hold their values whatever cmp_in does.
- R9: The result reaches +1024 when leg 0 counts every tick and leg 1 none, and -1024 in the reverse case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Modulator tick strobe, one clock wide |
| start | input | 1 | Request a two-leg conversion |
| settle_ticks | input | 8 | Ticks discarded after start and after the leg switch |
| cmp_in | input | 1 | Comparator decision, 1 when reference is above the integrator node |
| fb_out | output | 1 | Feedback level to the RC integrator |
| leg_sel | output | 1 | Bridge leg select, 0 first leg, 1 second leg |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse when result is valid |
| result | output | 12 | Signed differential count, leg 0 minus leg 1 |

## Verification
Every result here is one register away from its stimulus: fb_out and leg_sel reflect a tick on the clock that samples it, busy follows a start by one clock, and done, result and busy falling appear together one clock after the final counting tick. The bench therefore drives tick_en and cmp_in on the falling edge, lets exactly one rising edge pass and samples at the next falling edge, checking leg_sel before each tick and fb_out after it. Settling and gap phases deliberately drive cmp_in high or opposite so that any counted or leaked sample would move the result, and the closed-loop scenario models the integrator tick by tick so the expected difference follows from the two leg inputs alone.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_MEAS   = 2'd2
  } phase_t;
endpackage

// File: rtl/dsm_window_ctr.sv
module dsm_window_ctr #(
  parameter int LEN = 1024,
  parameter int W   = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic         last
);
  localparam logic [W-1:0] LAST_IDX = W'(LEN - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/dsm_ones_acc.sv
module dsm_ones_acc #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic         bit_in,
  output logic [W-1:0] sum,
  output logic [W-1:0] sum_next
);
  assign sum_next = sum + W'(bit_in);

  always_ff @(posedge clk) begin
    if (rst || clr) sum <= '0;
    else if (adv)   sum <= sum_next;
  end
endmodule

// File: rtl/dsm_settle_ctr.sv
module dsm_settle_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  output logic         at_one
);
  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                     remain <= '0;
    else if (load)               remain <= load_val;
    else if (adv && remain != 0) remain <= remain - 1'b1;
  end

  assign at_one = (remain == W'(1));
endmodule

// File: rtl/dsm_leg_diff.sv
module dsm_leg_diff #(
  parameter int CW = 11,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_first,
  input  logic          cap_second,
  input  logic [CW-1:0] count_in,
  output logic [RW-1:0] result
);
  logic [CW-1:0] first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      result  <= '0;
    end else begin
      if (cap_first)  first_q <= count_in;
      if (cap_second) result  <= RW'({1'b0, first_q}) - RW'({1'b0, count_in});
    end
  end
endmodule

// File: rtl/bridge_dsm_ctrl.sv
module bridge_dsm_ctrl #(
  parameter int WIN_LEN  = 1024,
  parameter int SETTLE_W = 8,
  localparam int CNT_W   = $clog2(WIN_LEN) + 1,
  localparam int RES_W   = CNT_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_ticks,
  input  logic                cmp_in,
  output logic                fb_out,
  output logic                leg_sel,
  output logic                busy,
  output logic                done,
  output logic [RES_W-1:0]    result
);
  import dsm_pkg::*;

  phase_t              phase;
  logic [SETTLE_W-1:0] settle_q;
  logic [CNT_W-1:0]    win_cnt;
  logic [CNT_W-1:0]    ones_sum;
  logic [CNT_W-1:0]    ones_next;
  logic                win_last;
  logic                settle_one;

  logic take_start, meas_tick, settle_tick, win_end, settle_done;
  logic settle_load;
  logic [SETTLE_W-1:0] settle_val;

  always_comb begin
    take_start  = (phase == PH_IDLE) && start;
    meas_tick   = (phase == PH_MEAS) && tick_en;
    settle_tick = (phase == PH_SETTLE) && tick_en;
    win_end     = meas_tick && win_last;
    settle_done = settle_tick && settle_one;
    settle_load = take_start || (win_end && !leg_sel);
    settle_val  = take_start ? settle_ticks : settle_q;
  end

  dsm_window_ctr #(.LEN(WIN_LEN), .W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .clr(take_start || win_end), .adv(meas_tick),
    .cnt(win_cnt), .last(win_last)
  );

  dsm_ones_acc #(.W(CNT_W)) u_ones (
    .clk(clk), .rst(rst), .clr(take_start || win_end), .adv(meas_tick),
    .bit_in(cmp_in), .sum(ones_sum), .sum_next(ones_next)
  );

  dsm_settle_ctr #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst(rst), .load(settle_load), .load_val(settle_val),
    .adv(settle_tick), .at_one(settle_one)
  );

  dsm_leg_diff #(.CW(CNT_W), .RW(RES_W)) u_diff (
    .clk(clk), .rst(rst),
    .cap_first(win_end && !leg_sel), .cap_second(win_end && leg_sel),
    .count_in(ones_next), .result(result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      settle_q <= '0;
      leg_sel  <= 1'b0;
      fb_out   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase != PH_IDLE && tick_en) fb_out <= ~cmp_in;
      if (take_start) begin
        settle_q <= settle_ticks;
        leg_sel  <= 1'b0;
        phase    <= (settle_ticks == '0) ? PH_MEAS : PH_SETTLE;
      end else if (settle_done) begin
        phase <= PH_MEAS;
      end else if (win_end) begin
        if (!leg_sel) begin
          leg_sel <= 1'b1;
          phase   <= (settle_q == '0) ? PH_MEAS : PH_SETTLE;
        end else begin
          leg_sel <= 1'b0;
          done    <= 1'b1;
          phase   <= PH_IDLE;
        end
      end
    end
  end

  assign busy = (phase != PH_IDLE);
endmodule

// File: rtl/dsm_ctrl_checker.sv
module dsm_ctrl_checker #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             start,
  input logic             cmp_in,
  input logic             fb_out,
  input logic             leg_sel,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result
);
  assert_start_takes_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !leg_sel));

  assert_fb_inverts_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && tick_en) |=> (fb_out == !$past(cmp_in)));

  assert_leg_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick_en) |=> $stable(leg_sel));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_result_only_on_done_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  assert_fb_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_en) |-> $stable(fb_out));
endmodule

bind bridge_dsm_ctrl dsm_ctrl_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .start(start), .cmp_in(cmp_in),
  .fb_out(fb_out), .leg_sel(leg_sel), .busy(busy), .done(done), .result(result)
);

// File: tb/bridge_dsm_ctrl_test.sv
`timescale 1ns/1ps
module bridge_dsm_ctrl_test;
  localparam int WIN = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  settle_ticks = 8'd0;
  logic        cmp_in = 1'b0;
  logic        fb_out, leg_sel, busy, done;
  logic [11:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  bridge_dsm_ctrl uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .start(start),
    .settle_ticks(settle_ticks), .cmp_in(cmp_in), .fb_out(fb_out),
    .leg_sel(leg_sel), .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pat(input int id, input int k);
    case (id)
      0: pat = (k % 3 == 0);
      1: pat = ((k * 7) % 5 < 2);
      2: pat = 1'b1;
      3: pat = 1'b0;
      default: pat = (k % 2 == 1);
    endcase
  endfunction

  function automatic int sx12(input logic [11:0] v);
    sx12 = int'($signed(v));
  endfunction

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R1 idle busy after reset", busy, 0);
    chk(!done, "R6 done after reset", done, 0);
    chk(!leg_sel, "R5 leg after reset", leg_sel, 0);
    chk(!fb_out, "R2 fb after reset", fb_out, 0);
    chk(result == 0, "R3 result after reset", sx12(result), 0);
  endtask

  task automatic run_conv(input int s, input int id0, input int id1,
                          input int gap, input bit poke);
    int exp0;
    int exp1;
    int total;
    exp0 = 0;
    exp1 = 0;
    total = 2 * s + 2 * WIN;
    settle_ticks = 8'(s);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle_ticks = 8'd0;
    chk(busy, "R1 busy after start", busy, 1);
    chk(!leg_sel, "R1 first leg after start", leg_sel, 0);
    for (int idx = 0; idx < total; idx++) begin
      logic c;
      if (idx < s) c = 1'b1;
      else if (idx < s + WIN) begin
        c = pat(id0, idx - s);
        exp0 += int'(c);
      end else if (idx < 2 * s + WIN) c = 1'b1;
      else begin
        c = pat(id1, idx - 2 * s - WIN);
        exp1 += int'(c);
      end
      chk(leg_sel == (idx >= s + WIN), "R5 leg select before tick",
          leg_sel, int'(idx >= s + WIN));
      tick_en = 1'b1;
      cmp_in = c;
      if (poke && idx == 700) start = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      start = 1'b0;
      chk(fb_out == !c, "R2 feedback inverts comparator", fb_out, int'(!c));
      if (idx == total - 1) begin
        chk(done, "R6 done pulse", done, 1);
        chk(!busy, "R6 busy low with done", busy, 0);
        chk(sx12(result) == exp0 - exp1, "R3 R4 R7 differential result",
            sx12(result), exp0 - exp1);
      end else begin
        chk(busy, "R3 busy during conversion", busy, 1);
      end
      if (gap > 0) begin
        cmp_in = c ^ 1'b1;
        repeat (gap) @(negedge clk);
        chk(fb_out == !c, "R8 feedback held without tick", fb_out, int'(!c));
      end
    end
    repeat (2) @(negedge clk);
    chk(!done, "R6 done single clock", done, 0);
    chk(!leg_sel, "R5 leg back to first", leg_sel, 0);
    chk(sx12(result) == exp0 - exp1, "R6 result held", sx12(result), exp0 - exp1);
  endtask

  task automatic run_extreme(input int id0, input int id1, input int expv);
    run_conv(2, id0, id1, 0, 1'b0);
    chk(sx12(result) == expv, "R9 extreme result", sx12(result), expv);
  endtask

  task automatic run_loop();
    int node;
    int va;
    int vb;
    int vin;
    int got;
    bit fin;
    node = 0;
    va = 300 + 40;
    vb = 700 + 40;
    fin = 1'b0;
    settle_ticks = 8'd16;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 3000 && !fin; t++) begin
      vin = leg_sel ? vb : va;
      node += fb_out ? (vin - WIN) : vin;
      cmp_in = (node < 0);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      if (done) fin = 1'b1;
    end
    got = sx12(result);
    chk(fin, "R3 closed loop completes", int'(fin), 1);
    chk(got >= 396 && got <= 404, "R3 closed loop offset cancels", got, 400);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    test_reset();
    run_conv(5, 0, 1, 0, 1'b0);
    run_conv(0, 1, 0, 1, 1'b0);
    run_conv(3, 4, 0, 2, 1'b1);
    run_extreme(2, 3, 1024);
    run_extreme(3, 2, -1024);
    run_loop();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end
endmodule